// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller

This block sits between a processor's load/store port and a memory port that moves one word per handshake. It keeps a direct-mapped copy of recently used memory lines. Each word address maps to exactly one line slot, chosen by its index field. Only addresses that fall inside an inclusive window set by two input registers are cached. Every other access, and every access made while the enable input is low, goes straight to memory as a single-word transfer.

The write policy is fixed at elaboration time by a parameter. In write-through mode every store reaches memory, and a store miss does not allocate a line. In write-back mode stores stay in the cache and mark the line dirty. A dirty line is written back before its slot is reused. A line-maintenance request invalidates the slot that its address selects, and in write-back mode it first writes back that slot's dirty contents. Each stored word carries a parity bit. In write-through mode a parity mismatch on a hit drops the line and refills it from memory. A fault-injection input inverts the parity bit stored by a store, so that this path can be exercised.

Tags are held in small synchronous RAMs that block RAM can implement, and so is line data. Valid and dirty bits are held in flops, so reset clears them in a single cycle.

Top module: `dcache_ctrl`

## Requirements
- R1: After reset, `cpu_ready` is 1, while `cpu_done` and `mem_req` are 0, and no line is valid: the first cacheable read misses.
- R2: A cacheable read miss reads all LINE_WORDS words of the line from memory, in ascending order starting at offset 0, and then returns the requested word. Later reads of that line make no memory access. The address is a word address laid out as {tag, index[5:2], offset[1:0]} for the default parameters.
- R3: Two cacheable addresses with the same index but different tags evict each other, so alternating between them refills the line every time.
- R4: An address below `win_lo` or above `win_hi` (both bounds inclusive) is served by exactly one single-word memory access and leaves the cache contents unchanged.
- R5: While `cache_on` is 0, every access makes one single-word memory access. Lines that were valid before are kept, and they hit again once `cache_on` returns to 1.
- R6: With WRITE_BACK=0, every store makes exactly one memory write. A store hit also updates the cached word. A store miss allocates nothing, so the next read of that line misses.
- R7: With WRITE_BACK=1, a store hit makes no memory access and marks the line dirty. A store miss fills the line and then merges the stored word. A miss on a dirty line first writes all of its words back, in ascending order, and then refills.
- R8: A request with `cpu_inval`=1 invalidates the line at the index of `cpu_addr`. With WRITE_BACK=1 and a dirty line, it first writes back all LINE_WORDS words. A clean line is dropped with no memory access.
- R9: With WRITE_BACK=0 and PARITY_EN=1, a word stored with `par_inject`=1 gets an inverted parity bit. The next read hit on it detects the error, drops the line, refills it from memory and returns the memory value.
- R10: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ack`. `mem_req` is never high while the controller is idle.
- R11: `cpu_done` is a one-cycle pulse that occurs only in the cycle where `cpu_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_on | input | 1 | Cache enable; when low all accesses bypass the arrays |
| win_lo | input | AW | Lowest cacheable word address (inclusive) |
| win_hi | input | AW | Highest cacheable word address (inclusive) |
| cpu_req | input | 1 | Request strobe, taken when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_inval | input | 1 | 1 = line maintenance (invalidate, with flush in write-back mode) |
| par_inject | input | 1 | Inverts the parity bit stored by this store |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Store data |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Load data, valid with `cpu_done` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |

## Verification
The bench builds two copies of the block side by side, both with 10-bit word addresses, 4-word lines and 16 lines. One copy is write-through with parity checking active, the other is write-back. The write-through copy exercises store-around on misses, stores that always reach memory, and the injected parity error that turns a hit into a refill. The write-back copy exercises dirty eviction ahead of a refill, merging on a store miss, and flush-then-invalidate against a clean invalidate. Because the lines are small and few, a conflict on index 1 and index 2 can be forced with a handful of addresses, and the ascending order of fills and write-backs can be logged word by word.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_BYPASS,
    ST_WB_RD,
    ST_WB_WR,
    ST_FILL,
    ST_FINISH
  } dc_state_t;
endpackage

// File: rtl/dcache_sdpram.sv
module dcache_sdpram #(
  parameter int W = 8,
  parameter int D = 16
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [$clog2(D)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(D)-1:0] raddr,
  output logic [W-1:0]         rdata
);
  logic [W-1:0] store_m [D];

  always_ff @(posedge clk) begin
    if (we) store_m[waddr] <= wdata;
    rdata <= store_m[raddr];
  end
endmodule

// File: rtl/dcache_addr_split.sv
module dcache_addr_split #(
  parameter int AW   = 10,
  parameter int OFFW = 2,
  parameter int IDXW = 4
) (
  input  logic [AW-1:0]           addr,
  input  logic [AW-1:0]           lo,
  input  logic [AW-1:0]           hi,
  output logic [AW-OFFW-IDXW-1:0] tag,
  output logic [IDXW-1:0]         idx,
  output logic [OFFW-1:0]         off,
  output logic                    in_win
);
  localparam int TAGW = AW - OFFW - IDXW;

  assign off    = addr[OFFW-1:0];
  assign idx    = addr[OFFW +: IDXW];
  assign tag    = addr[AW-1 -: TAGW];
  assign in_win = (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl #(
  parameter int AW         = 10,
  parameter int DW         = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 16,
  parameter bit WRITE_BACK = 1'b0,
  parameter bit PARITY_EN  = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cache_on,
  input  logic [AW-1:0] win_lo,
  input  logic [AW-1:0] win_hi,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic          cpu_inval,
  input  logic          par_inject,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  import dcache_pkg::*;

  localparam int OFFW  = $clog2(LINE_WORDS);
  localparam int IDXW  = $clog2(LINES);
  localparam int TAGW  = AW - OFFW - IDXW;
  localparam int DEPTH = LINES * LINE_WORDS;
  localparam int EW    = DW + 1;
  localparam bit CHK   = PARITY_EN && !WRITE_BACK;
  localparam logic [OFFW-1:0] LAST = OFFW'(LINE_WORDS - 1);

  dc_state_t st_q;

  logic [TAGW-1:0] c_tag;
  logic [IDXW-1:0] c_idx;
  logic [OFFW-1:0] c_off;
  logic            c_win;

  logic [TAGW-1:0] tag_q, vtag_q;
  logic [IDXW-1:0] idx_q;
  logic [OFFW-1:0] off_q, cnt_q;
  logic            we_q, inval_q, inj_q, cach_q;
  logic [DW-1:0]   wdata_q, hold_q;
  logic [LINES-1:0] valid_q, dirty_q;

  logic [IDXW+OFFW-1:0] d_raddr, d_waddr;
  logic [EW-1:0]        d_rdata, d_wdata;
  logic                 d_we;
  logic [IDXW-1:0]      t_raddr;
  logic [TAGW-1:0]      t_rdata;
  logic                 t_we;

  logic hit, perr, line_dirty, wr_hit;

  dcache_addr_split #(.AW(AW), .OFFW(OFFW), .IDXW(IDXW)) u_split (
    .addr(cpu_addr), .lo(win_lo), .hi(win_hi),
    .tag(c_tag), .idx(c_idx), .off(c_off), .in_win(c_win)
  );

  dcache_sdpram #(.W(EW), .D(DEPTH)) u_data (
    .clk(clk), .we(d_we), .waddr(d_waddr), .wdata(d_wdata),
    .raddr(d_raddr), .rdata(d_rdata)
  );

  dcache_sdpram #(.W(TAGW), .D(LINES)) u_tag (
    .clk(clk), .we(t_we), .waddr(idx_q), .wdata(tag_q),
    .raddr(t_raddr), .rdata(t_rdata)
  );

  assign cpu_ready = (st_q == ST_IDLE);

  // Lookup decode
  assign hit        = valid_q[idx_q] && (t_rdata == tag_q);
  assign line_dirty = WRITE_BACK && valid_q[idx_q] && dirty_q[idx_q];

  generate
    if (CHK) begin : g_par_chk
      assign perr = ^d_rdata;
    end else begin : g_par_off
      assign perr = 1'b0;
    end
  endgenerate

  assign wr_hit = (st_q == ST_LOOKUP) && !inval_q && cach_q && hit && !perr && we_q;

  // RAM addressing
  always_comb begin
    case (st_q)
      ST_IDLE:            d_raddr = {c_idx, c_off};
      ST_WB_RD, ST_WB_WR: d_raddr = {idx_q, cnt_q};
      default:            d_raddr = {idx_q, off_q};
    endcase
    t_raddr = (st_q == ST_IDLE) ? c_idx : idx_q;
  end

  always_comb begin
    d_we    = 1'b0;
    d_waddr = {idx_q, off_q};
    d_wdata = {(PARITY_EN ? (^wdata_q) ^ inj_q : 1'b0), wdata_q};
    if (st_q == ST_FILL) begin
      d_waddr = {idx_q, cnt_q};
      d_wdata = {(PARITY_EN ? ^mem_rdata : 1'b0), mem_rdata};
      d_we    = mem_req && mem_ack;
    end else if (wr_hit || (st_q == ST_FINISH && we_q)) begin
      d_we = 1'b1;
    end
  end

  assign t_we = (st_q == ST_FINISH);

  // Control
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      valid_q   <= '0;
      dirty_q   <= '0;
      tag_q     <= '0;
      vtag_q    <= '0;
      idx_q     <= '0;
      off_q     <= '0;
      cnt_q     <= '0;
      we_q      <= 1'b0;
      inval_q   <= 1'b0;
      inj_q     <= 1'b0;
      cach_q    <= 1'b0;
      wdata_q   <= '0;
      hold_q    <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cpu_req) begin
            tag_q   <= c_tag;
            idx_q   <= c_idx;
            off_q   <= c_off;
            we_q    <= cpu_we;
            inval_q <= cpu_inval;
            inj_q   <= par_inject;
            cach_q  <= cache_on && c_win;
            wdata_q <= cpu_wdata;
            st_q    <= ST_LOOKUP;
          end
        end

        ST_LOOKUP: begin
          vtag_q <= t_rdata;
          cnt_q  <= '0;
          if (inval_q) begin
            if (line_dirty) begin
              st_q <= ST_WB_RD;
            end else begin
              valid_q[idx_q] <= 1'b0;
              cpu_done       <= 1'b1;
              st_q           <= ST_IDLE;
            end
          end else if (!cach_q) begin
            st_q <= ST_BYPASS;
          end else if (hit && !perr) begin
            if (!we_q) begin
              cpu_rdata <= d_rdata[DW-1:0];
              cpu_done  <= 1'b1;
              st_q      <= ST_IDLE;
            end else if (WRITE_BACK) begin
              dirty_q[idx_q] <= 1'b1;
              cpu_done       <= 1'b1;
              st_q           <= ST_IDLE;
            end else begin
              st_q <= ST_BYPASS;
            end
          end else begin
            if (hit && perr) valid_q[idx_q] <= 1'b0;
            if (we_q && !WRITE_BACK) begin
              st_q <= ST_BYPASS;
            end else if (line_dirty) begin
              st_q <= ST_WB_RD;
            end else begin
              valid_q[idx_q] <= 1'b0;
              st_q           <= ST_FILL;
            end
          end
        end

        ST_BYPASS: begin
          if (!mem_req) begin
            mem_req   <= 1'b1;
            mem_we    <= we_q;
            mem_addr  <= {tag_q, idx_q, off_q};
            mem_wdata <= wdata_q;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            if (!we_q) cpu_rdata <= mem_rdata;
            cpu_done <= 1'b1;
            st_q     <= ST_IDLE;
          end
        end

        ST_WB_RD: st_q <= ST_WB_WR;

        ST_WB_WR: begin
          if (!mem_req) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {vtag_q, idx_q, cnt_q};
            mem_wdata <= d_rdata[DW-1:0];
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
              dirty_q[idx_q] <= 1'b0;
              valid_q[idx_q] <= 1'b0;
              if (inval_q) begin
                cpu_done <= 1'b1;
                st_q     <= ST_IDLE;
              end else begin
                st_q <= ST_FILL;
              end
            end else begin
              st_q <= ST_WB_RD;
            end
          end
        end

        ST_FILL: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= {tag_q, idx_q, cnt_q};
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == off_q) hold_q <= mem_rdata;
            if (cnt_q == LAST) st_q <= ST_FINISH;
          end
        end

        ST_FINISH: begin
          valid_q[idx_q] <= 1'b1;
          dirty_q[idx_q] <= we_q;
          if (!we_q) cpu_rdata <= hold_q;
          cpu_done <= 1'b1;
          st_q     <= ST_IDLE;
        end

        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcache_ctrl_chk.sv
module dcache_ctrl_chk #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_ready,
  input logic          cpu_done,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata
);
  AST_RESET_STATE: assert property (@(posedge clk) $past(rst) && !rst |-> cpu_ready && !cpu_done && !mem_req); // R1
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst) mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
  AST_NO_MEM_IDLE: assert property (@(posedge clk) disable iff (rst) cpu_ready |-> !mem_req); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) cpu_done |=> !cpu_done); // R11
  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst) cpu_done |-> cpu_ready && !$past(cpu_ready)); // R11
endmodule

bind dcache_ctrl dcache_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/dcache_ctrl_test.sv
module dcache_ctrl_test;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int MW = 1 << AW;

  typedef struct {
    bit          rd;
    logic [31:0] d;
    string       rq;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          con   [2];
  logic          req   [2];
  logic          we    [2];
  logic          inv   [2];
  logic          inj   [2];
  logic [AW-1:0] addr  [2];
  logic [DW-1:0] wd    [2];
  logic          rdy   [2];
  logic          done  [2];
  logic [DW-1:0] rdat  [2];
  logic          mreq  [2];
  logic          mwe   [2];
  logic [AW-1:0] maddr [2];
  logic [DW-1:0] mwd   [2];
  logic          mack  [2];
  logic [DW-1:0] mrd   [2];

  logic [AW-1:0] lo = 10'h040;
  logic [AW-1:0] hi = 10'h2FF;

  logic [DW-1:0] mem    [2][MW];
  logic [DW-1:0] shadow [2][MW];
  int nrd [2];
  int nwr [2];
  logic [AW-1:0] rdlog [$];
  logic [AW-1:0] wrlog [$];

  exp_t q0 [$];
  exp_t q1 [$];

  int total = 0;
  int bad = 0;
  bit finished = 0;

  dcache_ctrl #(.AW(AW), .DW(DW), .WRITE_BACK(1'b0), .PARITY_EN(1'b1)) uut (
    .clk(clk), .rst(rst), .cache_on(con[0]), .win_lo(lo), .win_hi(hi),
    .cpu_req(req[0]), .cpu_we(we[0]), .cpu_inval(inv[0]), .par_inject(inj[0]),
    .cpu_addr(addr[0]), .cpu_wdata(wd[0]), .cpu_ready(rdy[0]), .cpu_done(done[0]),
    .cpu_rdata(rdat[0]), .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_addr(maddr[0]),
    .mem_wdata(mwd[0]), .mem_ack(mack[0]), .mem_rdata(mrd[0])
  );

  dcache_ctrl #(.AW(AW), .DW(DW), .WRITE_BACK(1'b1), .PARITY_EN(1'b1)) uut_wb (
    .clk(clk), .rst(rst), .cache_on(con[1]), .win_lo(lo), .win_hi(hi),
    .cpu_req(req[1]), .cpu_we(we[1]), .cpu_inval(inv[1]), .par_inject(inj[1]),
    .cpu_addr(addr[1]), .cpu_wdata(wd[1]), .cpu_ready(rdy[1]), .cpu_done(done[1]),
    .cpu_rdata(rdat[1]), .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_addr(maddr[1]),
    .mem_wdata(mwd[1]), .mem_ack(mack[1]), .mem_rdata(mrd[1])
  );

  function automatic logic [31:0] init_word(input int i);
    return 32'hC0DE_0000 ^ (i * 32'h0001_0007);
  endfunction

  initial begin
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < MW; i++) begin
        mem[s][i]    = init_word(i);
        shadow[s][i] = init_word(i);
      end
  end

  // Memory model: one acknowledge per request, one cycle after it is seen
  always @(posedge clk) begin
    for (int s = 0; s < 2; s++) begin
      if (rst) begin
        mack[s] <= 1'b0;
        mrd[s]  <= '0;
        nrd[s]  <= 0;
        nwr[s]  <= 0;
      end else begin
        mack[s] <= mreq[s] && !mack[s];
        if (mreq[s] && !mack[s]) begin
          if (mwe[s]) begin
            mem[s][maddr[s]] <= mwd[s];
            nwr[s] <= nwr[s] + 1;
            if (s == 1) wrlog.push_back(maddr[s]);
          end else begin
            mrd[s] <= mem[s][maddr[s]];
            nrd[s] <= nrd[s] + 1;
            if (s == 0) rdlog.push_back(maddr[s]);
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard as completions appear
  initial begin
    forever begin
      @(negedge clk);
      for (int s = 0; s < 2; s++) begin
        if (!rst && done[s]) begin
          exp_t e;
          if ((s == 0 && q0.size() == 0) || (s == 1 && q1.size() == 0)) begin
            check(1'b0, "R11 unexpected done", 32'd1, 32'd0);
          end else begin
            e = (s == 0) ? q0.pop_front() : q1.pop_front();
            if (e.rd) check(rdat[s] === e.d, e.rq, rdat[s], e.d);
          end
        end
      end
    end
  end

  // Driver: pushes the expected item, issues the request, waits for completion
  task automatic access(input int s, input bit w, input bit iv, input bit pj,
                        input logic [AW-1:0] a, input logic [DW-1:0] d, input string rq);
    exp_t e;
    @(negedge clk);
    while (!rdy[s]) @(negedge clk);
    e.rd = !w && !iv;
    e.d  = shadow[s][a];
    e.rq = rq;
    if (w && !iv) shadow[s][a] = d;
    if (s == 0) q0.push_back(e); else q1.push_back(e);
    req[s] = 1'b1; we[s] = w; inv[s] = iv; inj[s] = pj; addr[s] = a; wd[s] = d;
    @(negedge clk);
    req[s] = 1'b0; we[s] = 1'b0; inv[s] = 1'b0; inj[s] = 1'b0;
    while (!rdy[s]) @(negedge clk);
  endtask

  task automatic traffic(input int s, input int r0, input int w0, input int er, input int ew, input string rq);
    check(nrd[s] - r0 == er, {rq, " reads"}, nrd[s] - r0, er);
    check(nwr[s] - w0 == ew, {rq, " writes"}, nwr[s] - w0, ew);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int r, w;
    for (int s = 0; s < 2; s++) begin
      con[s] = 1'b1; req[s] = 1'b0; we[s] = 1'b0; inv[s] = 1'b0; inj[s] = 1'b0;
      addr[s] = '0; wd[s] = '0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    for (int s = 0; s < 2; s++) begin
      check(rdy[s] === 1'b1, "R1 ready", rdy[s], 1);
      check(done[s] === 1'b0, "R1 done", done[s], 0);
      check(mreq[s] === 1'b0, "R1 mem_req", mreq[s], 0);
    end
    rst = 1'b0;
    @(negedge clk);

    // ---------- write-through copy ----------
    // R2 / R1: cold read miss fills the line in order
    rdlog.delete();
    r = nrd[0]; w = nwr[0];
    access(0, 0, 0, 0, 10'h106, 0, "R2 miss data");
    traffic(0, r, w, 4, 0, "R2 fill");
    check(rdlog.size() == 4, "R2 fill count", rdlog.size(), 4);
    for (int k = 0; k < 4; k++)
      if (rdlog.size() > k) check(rdlog[k] == 10'h104 + k, "R2 fill order", rdlog[k], 10'h104 + k);
    r = nrd[0]; w = nwr[0];
    access(0, 0, 0, 0, 10'h105, 0, "R2 hit data");
    traffic(0, r, w, 0, 0, "R2 hit");

    // R3: same index, other tag
    r = nrd[0]; w = nwr[0];
    access(0, 0, 0, 0, 10'h144, 0, "R3 conflict data");
    traffic(0, r, w, 4, 0, "R3 conflict");
    r = nrd[0];
    access(0, 0, 0, 0, 10'h105, 0, "R3 return data");
    traffic(0, r, w, 4, 0, "R3 return");

    // R4: outside the window on both sides
    r = nrd[0]; w = nwr[0];
    access(0, 0, 0, 0, 10'h300, 0, "R4 above data");
    access(0, 0, 0, 0, 10'h300, 0, "R4 above again");
    traffic(0, r, w, 2, 0, "R4 above");
    r = nrd[0];
    access(0, 0, 0, 0, 10'h03F, 0, "R4 below data");
    traffic(0, r, w, 1, 0, "R4 below");

    // R5: disable keeps contents
    con[0] = 1'b0;
    r = nrd[0];
    access(0, 0, 0, 0, 10'h105, 0, "R5 off data");
    traffic(0, r, w, 1, 0, "R5 off");
    con[0] = 1'b1;
    r = nrd[0];
    access(0, 0, 0, 0, 10'h106, 0, "R5 back on data");
    traffic(0, r, w, 0, 0, "R5 back on");

    // R6: store hit, store miss
    r = nrd[0]; w = nwr[0];
    access(0, 1, 0, 0, 10'h105, 32'h1234_5678, "R6 store hit");
    traffic(0, r, w, 0, 1, "R6 store hit");
    check(mem[0][10'h105] == 32'h1234_5678, "R6 memory word", mem[0][10'h105], 32'h1234_5678);
    r = nrd[0];
    access(0, 0, 0, 0, 10'h105, 0, "R6 updated word");
    traffic(0, r, w + 1, 0, 0, "R6 updated hit");
    r = nrd[0]; w = nwr[0];
    access(0, 1, 0, 0, 10'h208, 32'hAAAA_0001, "R6 store miss");
    traffic(0, r, w, 0, 1, "R6 store miss");
    r = nrd[0];
    access(0, 0, 0, 0, 10'h208, 0, "R6 no allocate data");
    traffic(0, r, w + 1, 4, 0, "R6 no allocate");

    // R8: invalidate in write-through
    r = nrd[0]; w = nwr[0];
    access(0, 0, 1, 0, 10'h208, 0, "R8 inval");
    traffic(0, r, w, 0, 0, "R8 inval wt");
    access(0, 0, 0, 0, 10'h209, 0, "R8 after inval data");
    traffic(0, r, w, 4, 0, "R8 after inval");

    // R9: injected parity error
    r = nrd[0]; w = nwr[0];
    access(0, 1, 0, 1, 10'h209, 32'h0BAD_0BAD, "R9 store inject");
    traffic(0, r, w, 0, 1, "R9 store inject");
    r = nrd[0];
    access(0, 0, 0, 0, 10'h209, 0, "R9 refilled data");
    traffic(0, r, w + 1, 4, 0, "R9 parity refill");
    r = nrd[0];
    access(0, 0, 0, 0, 10'h20A, 0, "R9 clean line data");
    traffic(0, r, w + 1, 0, 0, "R9 clean line");

    // ---------- write-back copy ----------
    r = nrd[1]; w = nwr[1];
    access(1, 0, 0, 0, 10'h104, 0, "R7 first fill");
    traffic(1, r, w, 4, 0, "R7 first fill");
    r = nrd[1];
    access(1, 1, 0, 0, 10'h105, 32'hDEAD_BEEF, "R7 store hit");
    traffic(1, r, w, 0, 0, "R7 store hit");
    access(1, 0, 0, 0, 10'h105, 0, "R7 dirty word");
    traffic(1, r, w, 0, 0, "R7 dirty read");

    wrlog.delete();
    r = nrd[1]; w = nwr[1];
    access(1, 0, 0, 0, 10'h144, 0, "R7 evict data");
    traffic(1, r, w, 4, 4, "R7 evict");
    for (int k = 0; k < 4; k++)
      if (wrlog.size() > k) check(wrlog[k] == 10'h104 + k, "R7 writeback order", wrlog[k], 10'h104 + k);
    check(mem[1][10'h105] == 32'hDEAD_BEEF, "R7 written back", mem[1][10'h105], 32'hDEAD_BEEF);

    r = nrd[1]; w = nwr[1];
    access(1, 1, 0, 0, 10'h188, 32'h5555_AAAA, "R7 store miss");
    traffic(1, r, w, 4, 0, "R7 store miss");
    r = nrd[1];
    access(1, 0, 0, 0, 10'h188, 0, "R7 merged word");
    traffic(1, r, w, 0, 0, "R7 merged hit");

    // R8: flush a dirty line, drop a clean one
    r = nrd[1]; w = nwr[1];
    access(1, 0, 1, 0, 10'h188, 0, "R8 flush");
    traffic(1, r, w, 0, 4, "R8 flush");
    check(mem[1][10'h188] == 32'h5555_AAAA, "R8 flushed word", mem[1][10'h188], 32'h5555_AAAA);
    w = nwr[1];
    access(1, 0, 0, 0, 10'h18A, 0, "R8 after flush data");
    traffic(1, r, w, 4, 0, "R8 after flush");
    r = nrd[1]; w = nwr[1];
    access(1, 0, 1, 0, 10'h144, 0, "R8 clean inval");
    traffic(1, r, w, 0, 0, "R8 clean inval");
    access(1, 0, 0, 0, 10'h145, 0, "R8 after clean data");
    traffic(1, r, w, 4, 0, "R8 after clean");

    // R4: uncached store in write-back mode still reaches memory
    r = nrd[1]; w = nwr[1];
    access(1, 1, 0, 0, 10'h300, 32'h0000_7777, "R4 wb uncached store");
    traffic(1, r, w, 0, 1, "R4 wb uncached store");

    repeat (3) @(negedge clk);
    check(q0.size() == 0 && q1.size() == 0, "R11 scoreboard drained", q0.size() + q1.size(), 0);
    finish_run();
  end
endmodule